// File: doc/BRIEF.md
# Address-Latched Multicart Bank Mapper

This block sits between an 8-bit console's CPU and PPU buses and the ROM on a multi-game cartridge. The CPU picks a game by writing anywhere in the upper half of its address space. The block ignores the byte written and takes the whole setup from the address lines of that write. The setup covers a program page, a pattern page, a shared outer-bank bit, a choice between a 32 KB program layout and a mirrored 16 KB layout, and the nametable mirroring direction.

From the latched setup, the block forms the program ROM address for the four 8 KB CPU windows and the pattern ROM address for the eight 1 KB PPU windows. It also forms the CIRAM A10 line. These three outputs are combinational, so they follow the live bus address with no added latency. The block also holds four nibble-wide scratch registers high in the 0x5xxx area. Reads lower in the expansion area return the high byte of the address, as an undriven bus would.

Top module: `addr_latch_mapper`

## Requirements
- R1: After a synchronous reset, the mapper is in its default state. CPU windows 0x8000, 0xA000, 0xC000 and 0xE000 select 8 KB banks 0, 1, 2 and 3. PPU window k selects 1 KB bank k. Mirroring is vertical. All four scratch registers read 0.
- R2: A write cycle (cpu_m2 high, cpu_rw low) at any address with A15 = 1 loads the setup at the next rising clock edge. The setup comes only from address bits 14..0. The data byte has no effect.
- R3: Address bit 13 of that write sets the mirroring: 1 is horizontal and 0 is vertical. ciram_a10 equals ppu_addr[11] when horizontal and ppu_addr[10] when vertical.
- R4: With write bit 12 = 0 (32 KB layout), prg_addr = bank×8192 + cpu_addr[12:0]. The bank is outer×128 + page×4 + w. Here w = cpu_addr[14:13], page = write bits 11..7 and outer = write bit 14.
- R5: With write bit 12 = 1 and write bit 6 = 0 (16 KB layout, lower half), windows 0x8000 and 0xC000 use offset 0, and windows 0xA000 and 0xE000 use offset 1.
- R6: With write bit 12 = 1 and write bit 6 = 1 (16 KB layout, upper half), windows 0x8000 and 0xC000 use offset 2, and windows 0xA000 and 0xE000 use offset 3.
- R7: The outer bit (write bit 14) adds 128 to every 8 KB program bank number and 512 to every 1 KB pattern bank number.
- R8: chr_addr = (outer×512 + cpage×8 + ppu_addr[12:10])×1024 + ppu_addr[9:0], where cpage = write bits 5..0.
- R9: A write cycle to 0x5800–0x5FFF stores data[3:0] into scratch register cpu_addr[1:0]. A read there returns that nibble with bits 7..4 zero.
- R10: A read (cpu_m2 high, cpu_rw high) of 0x4020–0x57FF returns cpu_addr[15:8] with cpu_rdata_oe = 1.
- R11: Writes to 0x4020–0x57FF change neither the scratch registers nor the setup. cpu_rdata_oe is 1 only for reads of 0x4020–0x5FFF.
- R12: The setup holds when cpu_m2 is low, during reads of 0x8000–0xFFFF, and during writes below 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Mapper clock; state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_m2 | input | 1 | CPU cycle-valid phase |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 14 | PPU address |
| prg_addr | output | 21 | Program ROM address |
| chr_addr | output | 20 | Pattern ROM address |
| ciram_a10 | output | 1 | Nametable RAM A10 |
| cpu_rdata | output | 8 | Read data for the expansion area |
| cpu_rdata_oe | output | 1 | Drive enable for cpu_rdata |

## Verification
The bench targets the three program layouts and checks every window in each.

- A design that swapped the half-select bit with the layout bit would show the 16 KB halves at the wrong offsets.
- A design that did not mirror the halves would give window 0xC000 offset 2 in the lower-half layout.

The bench also sets the outer bit together with all-ones pages. A design that let the page carry into the outer position, or that scaled only one of the two ROM outputs, would give the wrong bank numbers.

It writes identical addresses with opposite data bytes and writes just below 0x5800. It also makes writes with cpu_m2 low and reads in the upper area. A design that listened to the data byte, or decoded the scratch range too widely, would change state or read-back values that must stay fixed.

// File: rtl/alm_pkg.sv
// Shared constants and the setup record for the address-latched mapper.
// Assumes a 16-bit CPU bus, 8 KB program windows and 1 KB pattern windows.
package alm_pkg;
    localparam int CPU_AW      = 16;
    localparam int PPU_AW      = 14;
    localparam int PRG_PAGE_W  = 5;
    localparam int CHR_PAGE_W  = 6;
    localparam int PRG_SLOT_W  = 2;                 // 4 x 8 KB per 32 KB
    localparam int CHR_SLOT_W  = 3;                 // 8 x 1 KB per 8 KB
    localparam int PRG_WIN_W   = 13;                // 8 KB window offset
    localparam int CHR_WIN_W   = 10;                // 1 KB window offset
    localparam int PRG_BANK_W  = 1 + PRG_PAGE_W + PRG_SLOT_W;
    localparam int CHR_BANK_W  = 1 + CHR_PAGE_W + CHR_SLOT_W;
    localparam int PRG_OUT_W   = PRG_BANK_W + PRG_WIN_W;
    localparam int CHR_OUT_W   = CHR_BANK_W + CHR_WIN_W;
    localparam int SCR_DEPTH   = 4;
    localparam int SCR_W       = 4;
    localparam int SCR_IDX_W   = $clog2(SCR_DEPTH);

    // Bit positions in the latching write address (behavioural, fixed).
    localparam int BIT_OUTER   = 14;
    localparam int BIT_MIRROR  = 13;
    localparam int BIT_LAYOUT  = 12;
    localparam int BIT_PPG_LO  = 7;
    localparam int BIT_HALF    = 6;
    localparam int BIT_CPG_LO  = 0;

    // Address ranges of the expansion area.
    localparam logic [CPU_AW-1:0] EXP_LO   = 16'h4020;
    localparam logic [CPU_AW-1:0] SCR_BASE = 16'h5800;
    localparam logic [CPU_AW-1:0] SCR_END  = 16'h5FFF;

    typedef struct packed {
        logic                  outer;
        logic [PRG_PAGE_W-1:0] prg_page;
        logic [CHR_PAGE_W-1:0] chr_page;
        logic                  half16;   // 1 = 16 KB mirrored layout
        logic                  half_hi;  // which 16 KB half in that layout
        logic                  mirror_h; // 1 = horizontal mirroring
    } map_cfg_t;
endpackage

// File: rtl/alm_cfg_latch.sv
// Setup register. Captures all mapping fields from the address of a
// qualified upper-area write; the data byte never reaches this module.
// Assumes wr_en is already qualified (cycle valid, write, A15 set).
module alm_cfg_latch
    import alm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CPU_AW-2:0]       addr,
    output map_cfg_t                cfg
);
    map_cfg_t cfg_q;
    map_cfg_t cfg_d;

    // Unpack the latching address into the setup fields.
    always_comb begin
        cfg_d.outer    = addr[BIT_OUTER];
        cfg_d.mirror_h = addr[BIT_MIRROR];
        cfg_d.half16   = addr[BIT_LAYOUT];
        cfg_d.prg_page = addr[BIT_PPG_LO +: PRG_PAGE_W];
        cfg_d.half_hi  = addr[BIT_HALF];
        cfg_d.chr_page = addr[BIT_CPG_LO +: CHR_PAGE_W];
    end

    // Hold the setup; clear to the power-on mapping under reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R12: no qualified write, no change.
    a_r12_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));
    // R2: page and outer fields follow the write address.
    a_r2_cfg_from_addr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q.prg_page == $past(addr[11:7])) &&
                  (cfg_q.outer == $past(addr[14])) &&
                  (cfg_q.chr_page == $past(addr[5:0])));
    // R3: mirroring follows write bit 13.
    a_r3_mirror_latch: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg_q.mirror_h == $past(addr[13]));
endmodule

// File: rtl/alm_prg_map.sv
// Program bank map. Forms the ROM address for the current 8 KB CPU
// window from the setup; purely combinational on the live address.
// Assumes the caller only uses prg_addr for cycles with A15 set.
module alm_prg_map
    import alm_pkg::*;
(
    input  map_cfg_t                cfg,
    input  logic [CPU_AW-2:0]       cpu_a,
    output logic [PRG_OUT_W-1:0]    prg_addr
);
    logic [PRG_SLOT_W-1:0] win;
    logic [PRG_SLOT_W-1:0] slot;
    logic [PRG_BANK_W-1:0] bank;

    assign win = cpu_a[PRG_WIN_W +: PRG_SLOT_W];

    // Pick the slot within the 32 KB group for the chosen layout.
    always_comb begin
        if (cfg.half16) slot = {cfg.half_hi, win[0]};
        else            slot = win;
    end

    // Join outer bit, page and slot into the 8 KB bank number.
    assign bank     = {cfg.outer, cfg.prg_page, slot};
    assign prg_addr = {bank, cpu_a[PRG_WIN_W-1:0]};

    // R5/R6: in the 16 KB layout the half select drives the slot high bit.
    always_comb begin
        if (cfg.half16) begin
            a_r6_half_select: assert (prg_addr[PRG_WIN_W+1] == cfg.half_hi);
            a_r5_half_mirror: assert (prg_addr[PRG_WIN_W] == cpu_a[PRG_WIN_W]);
        end
    end
endmodule

// File: rtl/alm_chr_map.sv
// Pattern bank map and nametable line. Forms the 1 KB pattern ROM
// address and CIRAM A10 from the setup and the live PPU address.
// Assumes pattern fetches use ppu_addr below 0x2000.
module alm_chr_map
    import alm_pkg::*;
(
    input  map_cfg_t                cfg,
    input  logic [PPU_AW-1:0]       ppu_a,
    output logic [CHR_OUT_W-1:0]    chr_addr,
    output logic                    ciram_a10
);
    logic [CHR_BANK_W-1:0] bank;
    logic                  unused_ppu_top;

    // Eight consecutive 1 KB banks make one contiguous 8 KB block.
    assign bank     = {cfg.outer, cfg.chr_page, ppu_a[CHR_WIN_W +: CHR_SLOT_W]};
    assign chr_addr = {bank, ppu_a[CHR_WIN_W-1:0]};

    // Select the nametable address line for the mirroring direction.
    always_comb begin
        if (cfg.mirror_h) ciram_a10 = ppu_a[11];
        else              ciram_a10 = ppu_a[10];
    end

    assign unused_ppu_top = ppu_a[PPU_AW-1];
endmodule

// File: rtl/alm_scratch.sv
// Nibble scratch file and expansion-area read path. Writes in the
// scratch range keep the low nibble; reads below it return the address
// high byte. Assumes wr_en/rd_en are already qualified by cpu_m2.
module alm_scratch
    import alm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [CPU_AW-1:0]       addr,
    input  logic [SCR_W-1:0]        wnib,
    output logic [7:0]              rdata,
    output logic                    rdata_oe
);
    logic [SCR_W-1:0]     regs [SCR_DEPTH];
    logic                 in_scr;
    logic                 in_low;
    logic [SCR_IDX_W-1:0] idx;

    assign in_scr = (addr >= SCR_BASE) && (addr <= SCR_END);
    assign in_low = (addr >= EXP_LO) && (addr < SCR_BASE);
    assign idx    = addr[SCR_IDX_W-1:0];

    // One nibble register per slot, each with its own write enable.
    for (genvar g = 0; g < SCR_DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && in_scr && (idx == SCR_IDX_W'(g)))
                regs[g] <= wnib;
        end
    end

    // Return the stored nibble, or the address high byte below the file.
    always_comb begin
        rdata_oe = rd_en && (in_scr || in_low);
        if (in_scr) rdata = {{(8-SCR_W){1'b0}}, regs[idx]};
        else        rdata = addr[15:8];
    end

    // R9: a scratch write lands in the addressed slot.
    a_r9_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_scr) |=> regs[$past(idx)] == $past(wnib));
    // R11: writes below the file leave every slot alone.
    a_r11_low_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_scr) |=> ($stable(regs[0]) && $stable(regs[1]) &&
                                $stable(regs[2]) && $stable(regs[3])));
    // R11: the read path drives only in read cycles.
    a_r11_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> rd_en);
    // R9: high nibble of a scratch read is zero.
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && in_scr) |-> rdata[7:4] == 4'h0);
endmodule

// File: rtl/addr_latch_mapper.sv
// Top of the address-latched multicart mapper. Decodes CPU cycles into
// a setup write and scratch accesses, and maps program and pattern
// addresses. Assumes cpu_m2/cpu_rw/cpu_addr are stable around clk edges.
module addr_latch_mapper
    import alm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_m2,
    input  logic                    cpu_rw,
    input  logic [15:0]             cpu_addr,
    input  logic [7:0]              cpu_wdata,
    input  logic [13:0]             ppu_addr,
    output logic [20:0]             prg_addr,
    output logic [19:0]             chr_addr,
    output logic                    ciram_a10,
    output logic [7:0]              cpu_rdata,
    output logic                    cpu_rdata_oe
);
    map_cfg_t cfg;
    logic     wr_cyc;
    logic     rd_cyc;
    logic     cfg_we;
    logic     unused_wdata_hi;

    // Qualify bus cycles.
    assign wr_cyc = cpu_m2 && !cpu_rw;
    assign rd_cyc = cpu_m2 && cpu_rw;
    assign cfg_we = wr_cyc && cpu_addr[CPU_AW-1];
    assign unused_wdata_hi = ^cpu_wdata[7:SCR_W];

    alm_cfg_latch u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_we),
        .addr  (cpu_addr[CPU_AW-2:0]),
        .cfg   (cfg)
    );

    alm_prg_map u_prg (
        .cfg      (cfg),
        .cpu_a    (cpu_addr[CPU_AW-2:0]),
        .prg_addr (prg_addr)
    );

    alm_chr_map u_chr (
        .cfg       (cfg),
        .ppu_a     (ppu_addr),
        .chr_addr  (chr_addr),
        .ciram_a10 (ciram_a10)
    );

    alm_scratch u_scr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_cyc),
        .rd_en    (rd_cyc),
        .addr     (cpu_addr),
        .wnib     (cpu_wdata[SCR_W-1:0]),
        .rdata    (cpu_rdata),
        .rdata_oe (cpu_rdata_oe)
    );

    // R7: one outer bit feeds both ROM outputs.
    a_r7_outer_shared: assert property (@(posedge clk) disable iff (!rst_n)
        prg_addr[PRG_OUT_W-1] == chr_addr[CHR_OUT_W-1]);
    // R1: the cycle after reset maps to the default banks.
    a_r1_reset_default: assert property (@(posedge clk)
        !rst_n |=> (prg_addr[PRG_OUT_W-1:PRG_WIN_W+PRG_SLOT_W] == '0) &&
                   (chr_addr[CHR_OUT_W-1:CHR_WIN_W+CHR_SLOT_W] == '0));
endmodule

// File: tb/addr_latch_mapper_tb.sv
module addr_latch_mapper_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_m2 = 1'b0;
    logic        cpu_rw = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [13:0] ppu_addr = 14'h0000;
    logic [20:0] prg_addr;
    logic [19:0] chr_addr;
    logic        ciram_a10;
    logic [7:0]  cpu_rdata;
    logic        cpu_rdata_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_latch_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_m2(cpu_m2), .cpu_rw(cpu_rw),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr),
        .prg_addr(prg_addr), .chr_addr(chr_addr), .ciram_a10(ciram_a10),
        .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe)
    );

    // Reference state, built from the requirements.
    int         m_outer, m_ppage, m_cpage;
    bit         m_half16, m_halfhi, m_mirh;
    logic [3:0] m_scr [4];

    // Kinds: 0 prg_addr, 1 chr_addr, 2 ciram_a10, 3 {oe,rdata}.
    typedef struct {
        int          kind;
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } sb_item_t;
    sb_item_t sbq[$];

    function automatic void model_reset();
        m_outer = 0; m_ppage = 0; m_cpage = 0;
        m_half16 = 0; m_halfhi = 0; m_mirh = 0;
        for (int i = 0; i < 4; i++) m_scr[i] = 4'h0;
    endfunction

    function automatic logic [31:0] exp_prg(input logic [15:0] a);
        int w, off, bank;
        w = (a >> 13) & 3;
        if (m_half16) off = (m_halfhi ? 2 : 0) + (w % 2);
        else          off = w;
        bank = m_outer * 128 + m_ppage * 4 + off;
        return 32'(bank * 8192 + (a % 8192));
    endfunction

    function automatic logic [31:0] exp_chr(input logic [13:0] p);
        int bank;
        bank = m_outer * 512 + m_cpage * 8 + ((p >> 10) & 7);
        return 32'(bank * 1024 + (p % 1024));
    endfunction

    // Monitor: compare queued expectations away from the active edge.
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            case (it.kind)
                0:       act = 32'(prg_addr);
                1:       act = 32'(chr_addr);
                2:       act = 32'(ciram_a10);
                default: act = 32'({cpu_rdata_oe, cpu_rdata});
            endcase
            total++;
            if ((act & it.mask) != (it.exp & it.mask)) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag,
                         act & it.mask, it.exp & it.mask);
            end
        end
    end

    task automatic push(input int k, input logic [31:0] e,
                        input logic [31:0] m, input string t);
        sb_item_t it;
        it.kind = k; it.exp = e; it.mask = m; it.tag = t;
        sbq.push_back(it);
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d,
                             input bit m2 = 1'b1);
        @(posedge clk); #1;
        cpu_addr = a; cpu_wdata = d; cpu_m2 = m2; cpu_rw = 1'b0;
        @(posedge clk); #1;
        cpu_m2 = 1'b0; cpu_rw = 1'b1;
        if (m2 && a[15]) begin
            m_outer = a[14]; m_mirh = a[13]; m_half16 = a[12];
            m_ppage = (a >> 7) & 31; m_halfhi = a[6]; m_cpage = a & 63;
        end
        if (m2 && a >= 16'h5800 && a <= 16'h5FFF) m_scr[a[1:0]] = d[3:0];
    endtask

    task automatic check_prg(input logic [15:0] a, input string t);
        @(posedge clk); #1;
        cpu_addr = a; cpu_m2 = 1'b0; cpu_rw = 1'b1;
        push(0, exp_prg(a), 32'h1FFFFF, t);
    endtask

    task automatic check_windows(input logic [12:0] low, input string t);
        for (int w = 0; w < 4; w++) check_prg(16'h8000 | (w << 13) | low, t);
    endtask

    task automatic check_chr(input logic [13:0] p, input string t);
        @(posedge clk); #1;
        ppu_addr = p;
        push(1, exp_chr(p), 32'hFFFFF, t);
    endtask

    task automatic check_mir(input logic [13:0] p, input string t);
        @(posedge clk); #1;
        ppu_addr = p;
        push(2, 32'(m_mirh ? p[11] : p[10]), 32'h1, t);
    endtask

    // Read cycle; when no drive is expected only the enable is compared.
    task automatic check_rd(input logic [15:0] a, input bit oe,
                            input logic [7:0] d, input string t);
        @(posedge clk); #1;
        cpu_addr = a; cpu_m2 = 1'b1; cpu_rw = 1'b1;
        push(3, {23'd0, oe, d}, oe ? 32'h1FF : 32'h100, t);
        @(posedge clk); #1;
        cpu_m2 = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1; rst_n = 1'b0;
        @(posedge clk); @(posedge clk); #1; rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: default mapping after reset.
        check_windows(13'h0123, "R1 prg default");
        check_chr(14'h1C05, "R1 chr default");
        check_mir(14'h0400, "R1 vertical default");
        check_mir(14'h0800, "R1 vertical default A11");
        for (int i = 0; i < 4; i++) check_rd(16'h5800 + 16'(i), 1'b1, 8'h00, "R1 scratch zero");

        // R4 / R8: 32 KB layout, page 5, pattern page 0x2A, data 0xFF.
        cpu_write(16'h82AA, 8'hFF);
        check_windows(13'h1ABC, "R4 32K windows");
        check_chr(14'h0000, "R8 chr bank 0 of block");
        check_chr(14'h1FFF, "R8 chr bank 7 of block");
        check_mir(14'h0C00, "R3 vertical after write");

        // R2: same address with another data byte gives same mapping.
        cpu_write(16'h82AA, 8'h00);
        check_windows(13'h0001, "R2 data ignored");

        // R3: bit 13 selects horizontal mirroring.
        cpu_write(16'hA2AA, 8'h00);
        check_mir(14'h0800, "R3 horizontal A11=1");
        check_mir(14'h0400, "R3 horizontal A10 only");

        // R5 / R7: outer set, 16 KB lower half, all-ones program page.
        cpu_write(16'hDF85, 8'h5A);
        check_windows(13'h0777, "R5 16K lower half R7 outer");
        check_chr(14'h0A3C, "R7 chr outer");

        // R6: 16 KB upper half, page 3.
        cpu_write(16'h91C0, 8'h00);
        check_windows(13'h0000, "R6 16K upper half");
        check_mir(14'h0400, "R3 back to vertical");

        // R7: outer with all-ones pages in the 32 KB layout.
        cpu_write(16'hCFBF, 8'h00);
        check_windows(13'h1FFF, "R7 outer max pages");
        check_chr(14'h1FFF, "R7 chr outer max");

        // R12: no change without a qualified upper write.
        cpu_write(16'h8000, 8'h00, 1'b0);
        check_windows(13'h0042, "R12 m2 low write");
        check_rd(16'hB000, 1'b0, 8'h00, "R12 upper read");
        check_windows(13'h0042, "R12 after upper read");
        cpu_write(16'h6000, 8'h00);
        check_windows(13'h0042, "R12 write below 0x8000");

        // R9: scratch store and read back, with aliasing across the range.
        cpu_write(16'h5801, 8'hAB);
        cpu_write(16'h5FFE, 8'h37);
        check_rd(16'h5801, 1'b1, 8'h0B, "R9 slot 1");
        check_rd(16'h5FFD, 1'b1, 8'h0B, "R9 slot 1 alias");
        check_rd(16'h5802, 1'b1, 8'h07, "R9 slot 2");

        // R11: writes just below the file change nothing.
        cpu_write(16'h57FF, 8'hFF);
        cpu_write(16'h4021, 8'hFF);
        check_rd(16'h5803, 1'b1, 8'h00, "R11 slot 3 untouched");
        check_rd(16'h5801, 1'b1, 8'h0B, "R11 slot 1 untouched");
        check_windows(13'h0042, "R11 setup untouched");

        // R10: open-bus style reads in the low expansion area.
        check_rd(16'h4567, 1'b1, 8'h45, "R10 mid area");
        check_rd(16'h4020, 1'b1, 8'h40, "R10 lowest");
        check_rd(16'h57FF, 1'b1, 8'h57, "R10 highest");
        check_rd(16'h401F, 1'b0, 8'h00, "R11 no drive below area");
        check_rd(16'h6000, 1'b0, 8'h00, "R11 no drive above area");

        // R1: reset mid-run restores the defaults.
        do_reset();
        check_windows(13'h0100, "R1 prg after reset");
        check_mir(14'h0800, "R1 mirroring after reset");
        check_rd(16'h5801, 1'b1, 8'h00, "R1 scratch after reset");

        repeat (3) @(posedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule